// File: doc/BRIEF.md
# Saturating Clear-on-Read Receive Error Tallies

This block keeps three 8-bit statistics counters for the receive side of a network controller. The counters track frames with alignment faults, frames with a bad CRC, and frames dropped for lack of buffer space. The receive logic raises a one-cycle strobe for each event. Each counter adds one per strobe and stops at a ceiling of 192. It never wraps, so a large count cannot fold back into a small one.

Software reads a counter with a read strobe and a 2-bit index. The binary count appears on the read data one cycle later, and the same edge clears that counter. If an event lands in the cycle of the read, the read returns the old value and the counter restarts at one, so no event is lost between the snapshot and the clear. A service flag is high while any counter has reached 128, which tells software to collect the counts before they saturate. The read side has no back-pressure: a read strobe is always taken, and its result is valid for exactly one cycle.

Top module: `err_tally`

## Requirements
- R1: Three independent counters exist. `inc_i[0]` counts alignment errors (index 0), `inc_i[1]` counts CRC errors (index 1) and `inc_i[2]` counts missed frames (index 2). Each cycle in which a strobe is high adds exactly one to its counter.
- R2: No counter ever exceeds 192 (0xC0). A strobe that arrives while its counter holds 192 leaves it at 192.
- R3: A read with `rd_en_i` high and `rd_idx_i` naming a counter sets that counter to zero at the same clock edge.
- R4: One cycle after `rd_en_i`, `rd_valid_o` is high for that single cycle and `rd_data_o[7:0]` holds the selected count as plain binary, sampled before the clear. `rd_valid_o` is low in every cycle that does not follow a read.
- R5: When a read and a strobe hit the same counter in the same cycle, the read returns the value from before that cycle and the counter becomes 1.
- R6: `service_o` is high exactly while at least one counter holds 128 or more, i.e. has bit 7 set.
- R7: A synchronous active-high `rst_i` sets every counter to zero and drives `rd_valid_o` and `service_o` low.
- R8: A read with `rd_idx_i` equal to 3 returns zero with `rd_valid_o` high and leaves every counter unchanged.
- R9: A read of one counter leaves the other two counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| inc_i | input | 3 | Per-counter event strobes (0 alignment, 1 CRC, 2 missed) |
| rd_en_i | input | 1 | Read strobe from the CPU |
| rd_idx_i | input | 2 | Index of the counter to read |
| rd_data_o | output | 8 | Registered count returned by the read |
| rd_valid_o | output | 1 | High in the cycle after a read |
| service_o | output | 1 | High while any count is at least 128 |

## Verification
The clear from a read and an increment from the receive logic can act on the same counter in the same edge. The bench provokes this with a read and a strobe on the same index in one cycle. It checks that the returned value is the pre-edge count and that a second read returns exactly 1. The collision is also provoked while the counter sits at the 192 ceiling, where the read must return 192 and the follow-up read must again return 1.

// File: rtl/err_tally_pkg.sv
package err_tally_pkg;
  parameter int TALLY_W   = 8;
  parameter int TALLY_NUM = 3;
  parameter int TALLY_CEIL = 192;
  parameter int TALLY_IDX_W = 2;
endpackage

// File: rtl/tally_cell.sv
module tally_cell #(
  parameter int W    = 8,
  parameter int CEIL = 192
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CEIL_V = W'(CEIL);
  localparam logic [W-1:0] ONE_V  = W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      // a strobe in the clearing cycle is kept as the first new event
      cnt_o <= inc_i ? ONE_V : '0;
    end else if (inc_i && (cnt_o < CEIL_V)) begin
      cnt_o <= cnt_o + ONE_V;
    end
  end
endmodule

// File: rtl/tally_rdport.sv
module tally_rdport #(
  parameter int W     = 8,
  parameter int NUM   = 3,
  parameter int IDX_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    rd_en_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  input  logic [NUM-1:0][W-1:0]   cnt_i,
  output logic [NUM-1:0]          clr_o,
  output logic [W-1:0]            rd_data_o,
  output logic                    rd_valid_o
);
  logic [W-1:0] sel_cnt;

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_idx_i == IDX_W'(i)) sel_cnt = cnt_i[i];
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_clr
    assign clr_o[g] = rd_en_i && (rd_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= sel_cnt;
    end
  end
endmodule

// File: rtl/err_tally.sv
module err_tally
  import err_tally_pkg::*;
#(
  parameter int W     = TALLY_W,
  parameter int NUM   = TALLY_NUM,
  parameter int CEIL  = TALLY_CEIL,
  parameter int IDX_W = TALLY_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NUM-1:0]   inc_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rd_data_o,
  output logic             rd_valid_o,
  output logic             service_o
);
  localparam int FLAG_BIT = W - 1;

  logic [NUM-1:0][W-1:0] cnt_q;
  logic [NUM-1:0]        clr;
  logic [NUM-1:0]        high;

  for (genvar g = 0; g < NUM; g++) begin : g_cell
    tally_cell #(.W(W), .CEIL(CEIL)) u_cell (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .inc_i (inc_i[g]),
      .clr_i (clr[g]),
      .cnt_o (cnt_q[g])
    );
    assign high[g] = cnt_q[g][FLAG_BIT];
  end

  tally_rdport #(.W(W), .NUM(NUM), .IDX_W(IDX_W)) u_rd (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .cnt_i      (cnt_q),
    .clr_o      (clr),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign service_o = |high;
endmodule

// File: rtl/err_tally_chk.sv
module err_tally_chk #(
  parameter int W     = 8,
  parameter int NUM   = 3,
  parameter int CEIL  = 192,
  parameter int IDX_W = 2
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic [NUM-1:0]        inc_i,
  input logic                  rd_en_i,
  input logic [IDX_W-1:0]      rd_idx_i,
  input logic [W-1:0]          rd_data_o,
  input logic                  rd_valid_o,
  input logic                  service_o,
  input logic [NUM-1:0][W-1:0] cnt_q
);
  localparam logic [W-1:0] CEIL_V = W'(CEIL);

  AST_VALID_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid_o |-> $past(rd_en_i)); // R4

  AST_DATA_CAPPED: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid_o |-> (rd_data_o <= CEIL_V)); // R2

  AST_IDX3_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_valid_o && ($past(rd_idx_i) == IDX_W'(3))) |-> (rd_data_o == '0)); // R8

  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(service_o) |-> $past(|inc_i)); // R6

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q[g] <= CEIL_V); // R2

    AST_STICK_AT_CEIL: assert property (@(posedge clk_i) disable iff (rst_i)
      ((cnt_q[g] == CEIL_V) && !(rd_en_i && rd_idx_i == IDX_W'(g)))
        |=> (cnt_q[g] == CEIL_V)); // R2

    AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_en_i && rd_idx_i == IDX_W'(g) && !inc_i[g]) |=> (cnt_q[g] == '0)); // R3

    AST_MERGE_TO_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_en_i && rd_idx_i == IDX_W'(g) && inc_i[g]) |=> (cnt_q[g] == W'(1))); // R5

    AST_OTHERS_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_en_i && rd_idx_i != IDX_W'(g) && !inc_i[g]) |=> $stable(cnt_q[g])); // R9
  end
endmodule

bind err_tally err_tally_chk #(.W(W), .NUM(NUM), .CEIL(CEIL), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .inc_i      (inc_i),
  .rd_en_i    (rd_en_i),
  .rd_idx_i   (rd_idx_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .service_o  (service_o),
  .cnt_q      (cnt_q)
);

// File: tb/tb_err_tally.sv
module tb_err_tally;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] inc = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       service;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  err_tally dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .inc_i      (inc),
    .rd_en_i    (rd_en),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid),
    .service_o  (service)
  );

  // row: [15:13] strobes, [12] read, [11:10] index, [7:0] expected read data
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {3'b001, 1'b0, 2'd0, 2'b00, 8'd0},
    {3'b001, 1'b0, 2'd0, 2'b00, 8'd0},
    {3'b110, 1'b0, 2'd0, 2'b00, 8'd0},
    {3'b000, 1'b1, 2'd0, 2'b00, 8'd2},
    {3'b000, 1'b1, 2'd0, 2'b00, 8'd0},
    {3'b010, 1'b1, 2'd1, 2'b00, 8'd1},
    {3'b000, 1'b1, 2'd1, 2'b00, 8'd1},
    {3'b000, 1'b1, 2'd3, 2'b00, 8'd0},
    {3'b000, 1'b1, 2'd2, 2'b00, 8'd1},
    {3'b100, 1'b1, 2'd2, 2'b00, 8'd0},
    {3'b000, 1'b1, 2'd2, 2'b00, 8'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge pass, sample on the next falling edge
  task automatic cyc(input logic [2:0] s, input logic r, input logic [1:0] ix);
    inc = s; rd_en = r; rd_idx = ix;
    @(negedge clk);
    inc = '0; rd_en = 1'b0; rd_idx = '0;
  endtask

  task automatic rd_chk(input logic [1:0] ix, input int exp, input string tag);
    cyc(3'b000, 1'b1, ix);
    check({tag, " valid"}, int'(rd_valid), 1);
    check({tag, " data"}, int'(rd_data), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    check("R7 valid after reset", int'(rd_valid), 0);
    check("R7 flag after reset", int'(service), 0);
    rd_chk(2'd0, 0, "R7 cnt0");
    rd_chk(2'd1, 0, "R7 cnt1");
    rd_chk(2'd2, 0, "R7 cnt2");
    cyc(3'b000, 1'b0, 2'd0);
    check("R4 valid drops", int'(rd_valid), 0);

    // table walk: R1 R3 R4 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][15:13], VEC[v][12], VEC[v][11:10]);
      if (VEC[v][12]) begin
        check($sformatf("R1/R3/R5/R8/R9 row %0d valid", v), int'(rd_valid), 1);
        check($sformatf("R1/R3/R5/R8/R9 row %0d data", v), int'(rd_data), int'(VEC[v][7:0]));
      end else begin
        check($sformatf("R4 row %0d idle valid", v), int'(rd_valid), 0);
      end
    end

    // R6 threshold on counter 1
    for (int k = 0; k < 127; k++) cyc(3'b010, 1'b0, 2'd0);
    check("R6 flag at 127", int'(service), 0);
    cyc(3'b010, 1'b0, 2'd0);
    check("R6 flag at 128", int'(service), 1);
    rd_chk(2'd1, 128, "R6 read 128");
    check("R6 flag cleared", int'(service), 0);

    // R2 saturation on counter 0
    for (int k = 0; k < 200; k++) cyc(3'b001, 1'b0, 2'd0);
    check("R6 flag at ceiling", int'(service), 1);
    rd_chk(2'd0, 192, "R2 saturate");
    rd_chk(2'd0, 0, "R3 cleared after ceiling");

    // R5 collision at the ceiling on counter 2
    for (int k = 0; k < 195; k++) cyc(3'b100, 1'b0, 2'd0);
    cyc(3'b100, 1'b1, 2'd2);
    check("R5 ceiling collision data", int'(rd_data), 192);
    rd_chk(2'd2, 1, "R5 ceiling collision remainder");

    // R8 index 3 leaves a loaded counter alone
    cyc(3'b001, 1'b0, 2'd0);
    cyc(3'b001, 1'b0, 2'd0);
    rd_chk(2'd3, 0, "R8 index 3");
    rd_chk(2'd0, 2, "R8 counter kept");

    // R7 reset mid-run
    for (int k = 0; k < 130; k++) cyc(3'b001, 1'b0, 2'd0);
    rst = 1'b1;
    cyc(3'b000, 1'b1, 2'd0);
    rst = 1'b0;
    check("R7 flag after late reset", int'(service), 0);
    check("R7 valid after late reset", int'(rd_valid), 0);
    rd_chk(2'd0, 0, "R7 count after late reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule